// File: doc/BRIEF.md
# MESI Cache Bus Snoop Responder

This block sits beside one data cache and watches transactions that other bus masters place on the shared bus. For each coherent transaction it looks up the addressed block in a direct-mapped tag and state table. It then decides the snoop response from two inputs: the transfer-type code and the block's MESI state. It can answer with the shared signal, the address-retry signal, both, or neither. When a block has to be pushed to memory first, it asks for a castout of the dirty data, and it updates the block's MESI state once that castout is done.

Next to the data cache table the block keeps a valid/tag table for the instruction cache. An instruction-block-invalidate snoop clears entries in that table. The block also holds a single load-reserve reservation. A snooped kill of the reserved block cancels the reservation. A flush that only removes the cached copy leaves the reservation in place, so a later reserved load misses and has to issue an atomic bus read.

Fill ports preload both tables. A combinational lookup port reports the stored state of any address. A reserved-load port reports whether the load hit the cache or needs an atomic read.

Top module: `snoop_responder`

## Requirements
- R1: An address splits into block offset addr[4:0], set index addr[8:5] and tag addr[31:9]. A lookup matches on index and tag only, and the offset never affects the result. States are encoded Invalid=0, Shared=1, Exclusive=2, Modified=3. `look_dstate` shows the stored state when the tag matches and 0 otherwise. `look_ivalid` shows a tag-matched valid instruction entry.
- R2: A snoop whose memory-coherence bit `snp_wim[0]` is 0 gives no response and changes no state.
- R3: A read-without-intent-to-cache snoop (type 5'b01011) that misses, or hits an Invalid block, gives no response and takes no action.
- R4: A type 5'b01011 snoop that hits a Shared or Exclusive block asserts only `resp_shared` and leaves the state unchanged.
- R5: A type 5'b01011 snoop that hits a Modified block asserts both `resp_retry` and `resp_shared`. It raises `co_req` with the block address (offset bits zero) and holds it until `co_ack`. If `co_ok` is 1 at the ack, the block becomes Exclusive. If `co_ok` is 0, the block stays Modified.
- R6: While `co_req` is high, every coherent snoop gets `resp_retry` alone and changes no state.
- R7: An instruction-block-invalidate snoop (type 5'b01101) gives no response. It clears the instruction entry only if the tag matches.
- R8: An ordering snoop (type 5'b10000) answers with `resp_retry` only and has no cache effect.
- R9: A kill snoop (type 5'b01100) gives no response. It sets a hit block to Invalid in any state, without a castout. If a valid reservation covers the same block, it clears the reservation.
- R10: A flush snoop (type 5'b00100) makes a Shared or Exclusive hit Invalid with no response. On a Modified hit it asserts only `resp_retry` and starts a castout that leaves the block Invalid on success. In every case the reservation is kept.
- R11: A reserved load (`lr_req`) pulses `lr_hit` one cycle later if its block is valid in the data cache, and pulses `lr_atomic` otherwise. In both cases it sets `rsv_valid` for that block.
- R12: Responses come from registers one cycle after the snoop and are low in any cycle that follows no snoop. After reset, all outputs are low and every entry is Invalid.
- R13: A coherent snoop with any other transfer type gives no response and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| snp_valid | input | 1 | A snooped transaction is on the bus this cycle |
| snp_tt | input | 5 | Transfer-type code of the snooped transaction |
| snp_wim | input | 3 | Storage attributes; bit 0 is memory coherence |
| snp_addr | input | 32 | Snooped address |
| resp_shared | output | 1 | Shared response |
| resp_retry | output | 1 | Address-retry response |
| co_req | output | 1 | Castout of a dirty block pending |
| co_addr | output | 32 | Block address of the pending castout |
| co_ack | input | 1 | Castout finished this cycle |
| co_ok | input | 1 | Finished castout succeeded |
| dfill_valid | input | 1 | Write a data-cache entry |
| dfill_addr | input | 32 | Address of the data-cache entry to write |
| dfill_state | input | 2 | MESI state to store |
| ifill_valid | input | 1 | Mark an instruction-cache entry valid |
| ifill_addr | input | 32 | Address of the instruction-cache entry |
| lr_req | input | 1 | Local reserved load issued |
| lr_addr | input | 32 | Address of the reserved load |
| lr_hit | output | 1 | Reserved load hit the data cache |
| lr_atomic | output | 1 | Reserved load needs an atomic bus read |
| rsv_valid | output | 1 | Reservation held |
| look_addr | input | 32 | Lookup address |
| look_dstate | output | 2 | Data-cache state at the lookup address |
| look_ivalid | output | 1 | Instruction entry valid at the lookup address |

## Verification
The assertions assume several things about the inputs. No fill arrives in the same cycle as a snoop. No data fill arrives while a castout is pending. A reserved load never coincides with a kill snoop. `co_ack` has meaning only while `co_req` is high. The stimulus keeps to these rules by issuing at most one of snoop, data fill, instruction fill or reserved load per cycle, and by holding back data fills while the reference model shows a castout pending. Acknowledges are driven at random, and the design must ignore those that arrive while idle. Addresses are drawn from two tags over four sets with random offsets, so hits, conflicting misses and offset aliasing all occur often.

// File: rtl/snp_pkg.sv
// Package: shared state encoding and snoop transfer-type codes.
// Assumes a 2-bit MESI code stored per data-cache entry.
package snp_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_t;

    localparam logic [4:0] TT_RD_NOCACHE = 5'b01011;
    localparam logic [4:0] TT_ICINV      = 5'b01101;
    localparam logic [4:0] TT_ORDER      = 5'b10000;
    localparam logic [4:0] TT_KILL       = 5'b01100;
    localparam logic [4:0] TT_FLUSH      = 5'b00100;
endpackage

// File: rtl/snp_tag_table.sv
// Direct-mapped tag table with DW bits of payload per set and NRD read ports.
// A read hits when the stored tag matches and the payload is nonzero; a miss
// reads payload zero. One write port; writes take effect at the next edge.
// Assumes the caller arbitrates among writers.
module snp_tag_table #(
    parameter int IDXW = 4,
    parameter int TAGW = 23,
    parameter int DW   = 2,
    parameter int NRD  = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NRD-1:0][IDXW-1:0]       rd_idx,
    input  logic [NRD-1:0][TAGW-1:0]       rd_tag,
    output logic [NRD-1:0]                 rd_hit,
    output logic [NRD-1:0][DW-1:0]         rd_data,
    input  logic                           we,
    input  logic [IDXW-1:0]                w_idx,
    input  logic [TAGW-1:0]                w_tag,
    input  logic [DW-1:0]                  w_data
);
    localparam int SETS = 1 << IDXW;

    logic [TAGW-1:0] tag_q [SETS];
    logic [DW-1:0]   dat_q [SETS];

    // Storage update: clear all payloads on reset, else apply the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                tag_q[s] <= '0;
                dat_q[s] <= '0;
            end
        end else if (we) begin
            tag_q[w_idx] <= w_tag;
            dat_q[w_idx] <= w_data;
        end
    end

    // One lookup per read port.
    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            rd_hit[p]  = (tag_q[rd_idx[p]] == rd_tag[p]) && (dat_q[rd_idx[p]] != '0);
            rd_data[p] = rd_hit[p] ? dat_q[rd_idx[p]] : '0;
        end
    end
endmodule

// File: rtl/snp_castout.sv
// One-entry castout buffer. Holds the block address and the state to install
// when memory accepts the data. Busy from start until an acknowledge.
// Assumes start is never raised while busy.
module snp_castout #(
    parameter int BLKW = 27
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [BLKW-1:0] start_blk,
    input  logic [1:0]      start_next,
    input  logic            ack,
    input  logic            ok,
    output logic            busy,
    output logic [BLKW-1:0] blk,
    output logic [1:0]      next_st,
    output logic            done_ok
);
    // Buffer state: load on start, release on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            blk     <= '0;
            next_st <= '0;
        end else if (busy) begin
            if (ack) busy <= 1'b0;
        end else if (start) begin
            busy    <= 1'b1;
            blk     <= start_blk;
            next_st <= start_next;
        end
    end

    // A successful acknowledge of a pending castout commits the new state.
    assign done_ok = busy && ack && ok;

    // R5: the request and its address stay put until acknowledged.
    a_r5_castout_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !ack |=> busy && $stable(blk));
endmodule

// File: rtl/snp_rsv.sv
// Single reservation register. A reserved load sets it; a kill of the same
// block clears it. Assumes set and kill do not arrive together.
module snp_rsv #(
    parameter int BLKW = 27
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set,
    input  logic [BLKW-1:0] set_blk,
    input  logic            kill,
    input  logic [BLKW-1:0] kill_blk,
    output logic            valid
);
    logic [BLKW-1:0] blk_q;

    // Reservation tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            blk_q <= '0;
        end else if (set) begin
            valid <= 1'b1;
            blk_q <= set_blk;
        end else if (kill && valid && (blk_q == kill_blk)) begin
            valid <= 1'b0;
        end
    end

    // R9: a kill that covers the reserved block drops the reservation.
    a_r9_kill_drops_rsv: assert property (@(posedge clk) disable iff (!rst_n)
        kill && !set && valid && (blk_q == kill_blk) |=> !valid);
endmodule

// File: rtl/snoop_responder.sv
// Snoop responder for one data cache. Decodes the transfer type of each
// coherent snooped transaction against the local MESI state and drives
// registered shared/retry responses, castouts, instruction-entry invalidates
// and the reservation. Assumes fills never coincide with snoops, data fills
// never arrive while a castout is pending, and reserved loads never coincide
// with kill snoops.
module snoop_responder
    import snp_pkg::*;
#(
    parameter int AW   = 32,
    parameter int OFFW = 5,
    parameter int IDXW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          snp_valid,
    input  logic [4:0]    snp_tt,
    input  logic [2:0]    snp_wim,
    input  logic [AW-1:0] snp_addr,
    output logic          resp_shared,
    output logic          resp_retry,
    output logic          co_req,
    output logic [AW-1:0] co_addr,
    input  logic          co_ack,
    input  logic          co_ok,
    input  logic          dfill_valid,
    input  logic [AW-1:0] dfill_addr,
    input  logic [1:0]    dfill_state,
    input  logic          ifill_valid,
    input  logic [AW-1:0] ifill_addr,
    input  logic          lr_req,
    input  logic [AW-1:0] lr_addr,
    output logic          lr_hit,
    output logic          lr_atomic,
    output logic          rsv_valid,
    input  logic [AW-1:0] look_addr,
    output logic [1:0]    look_dstate,
    output logic          look_ivalid
);
    localparam int TAGW = AW - OFFW - IDXW;
    localparam int BLKW = AW - OFFW;
    localparam int PSNP = 0;
    localparam int PLK  = 1;
    localparam int PLR  = 2;

    // Block addresses: offset bits dropped everywhere.
    logic [BLKW-1:0] snp_blk, look_blk, lr_blk, dfill_blk, ifill_blk;
    assign snp_blk   = snp_addr[AW-1:OFFW];
    assign look_blk  = look_addr[AW-1:OFFW];
    assign lr_blk    = lr_addr[AW-1:OFFW];
    assign dfill_blk = dfill_addr[AW-1:OFFW];
    assign ifill_blk = ifill_addr[AW-1:OFFW];

    // Data-cache table ports.
    logic [2:0][IDXW-1:0] d_rd_idx;
    logic [2:0][TAGW-1:0] d_rd_tag;
    logic [2:0]           d_hit;
    logic [2:0][1:0]      d_data;
    logic                 d_we;
    logic [IDXW-1:0]      d_w_idx;
    logic [TAGW-1:0]      d_w_tag;
    logic [1:0]           d_w_data;

    // Instruction-cache table ports.
    logic [1:0][IDXW-1:0] i_rd_idx;
    logic [1:0][TAGW-1:0] i_rd_tag;
    logic [1:0]           i_hit;
    logic [1:0][0:0]      i_data;
    logic                 i_we;
    logic [IDXW-1:0]      i_w_idx;
    logic [TAGW-1:0]      i_w_tag;
    logic [0:0]           i_w_data;

    // Castout buffer signals.
    logic            co_busy, co_done_ok, co_start;
    logic [BLKW-1:0] co_blk;
    logic [1:0]      co_next_q, co_next_d;

    // Snoop decision signals.
    logic       coherent;
    logic       sh_d, rt_d;
    logic       dw_snp;
    logic [1:0] dw_state;
    logic       i_clr;
    logic       rsv_kill;
    mesi_t      snp_state;

    // Read-port address split.
    always_comb begin
        d_rd_idx[PSNP] = snp_blk[IDXW-1:0];
        d_rd_tag[PSNP] = snp_blk[BLKW-1:IDXW];
        d_rd_idx[PLK]  = look_blk[IDXW-1:0];
        d_rd_tag[PLK]  = look_blk[BLKW-1:IDXW];
        d_rd_idx[PLR]  = lr_blk[IDXW-1:0];
        d_rd_tag[PLR]  = lr_blk[BLKW-1:IDXW];
        i_rd_idx[PSNP] = snp_blk[IDXW-1:0];
        i_rd_tag[PSNP] = snp_blk[BLKW-1:IDXW];
        i_rd_idx[PLK]  = look_blk[IDXW-1:0];
        i_rd_tag[PLK]  = look_blk[BLKW-1:IDXW];
    end

    snp_tag_table #(.IDXW(IDXW), .TAGW(TAGW), .DW(2), .NRD(3)) u_dtags (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (d_rd_idx),
        .rd_tag  (d_rd_tag),
        .rd_hit  (d_hit),
        .rd_data (d_data),
        .we      (d_we),
        .w_idx   (d_w_idx),
        .w_tag   (d_w_tag),
        .w_data  (d_w_data)
    );

    snp_tag_table #(.IDXW(IDXW), .TAGW(TAGW), .DW(1), .NRD(2)) u_itags (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (i_rd_idx),
        .rd_tag  (i_rd_tag),
        .rd_hit  (i_hit),
        .rd_data (i_data),
        .we      (i_we),
        .w_idx   (i_w_idx),
        .w_tag   (i_w_tag),
        .w_data  (i_w_data)
    );

    snp_castout #(.BLKW(BLKW)) u_castout (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (co_start),
        .start_blk  (snp_blk),
        .start_next (co_next_d),
        .ack        (co_ack),
        .ok         (co_ok),
        .busy       (co_busy),
        .blk        (co_blk),
        .next_st    (co_next_q),
        .done_ok    (co_done_ok)
    );

    snp_rsv #(.BLKW(BLKW)) u_rsv (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (lr_req),
        .set_blk  (lr_blk),
        .kill     (rsv_kill),
        .kill_blk (snp_blk),
        .valid    (rsv_valid)
    );

    assign coherent  = snp_valid && snp_wim[0];
    assign snp_state = mesi_t'(d_data[PSNP]);

    // Snoop decode: response, castout start and table actions per transfer type.
    always_comb begin
        sh_d      = 1'b0;
        rt_d      = 1'b0;
        co_start  = 1'b0;
        co_next_d = ST_I;
        dw_snp    = 1'b0;
        dw_state  = ST_I;
        i_clr     = 1'b0;
        rsv_kill  = 1'b0;
        if (coherent) begin
            if (co_busy) begin
                rt_d = 1'b1;
            end else begin
                case (snp_tt)
                    TT_RD_NOCACHE: begin
                        if (snp_state == ST_M) begin
                            rt_d      = 1'b1;
                            sh_d      = 1'b1;
                            co_start  = 1'b1;
                            co_next_d = ST_E;
                        end else if (snp_state != ST_I) begin
                            sh_d = 1'b1;
                        end
                    end
                    TT_ICINV: begin
                        i_clr = i_hit[PSNP];
                    end
                    TT_ORDER: begin
                        rt_d = 1'b1;
                    end
                    TT_KILL: begin
                        dw_snp   = d_hit[PSNP];
                        rsv_kill = 1'b1;
                    end
                    TT_FLUSH: begin
                        if (snp_state == ST_M) begin
                            rt_d      = 1'b1;
                            co_start  = 1'b1;
                            co_next_d = ST_I;
                        end else begin
                            dw_snp = d_hit[PSNP];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Data-table write arbitration: castout commit, then snoop, then fill.
    always_comb begin
        d_we     = 1'b1;
        d_w_idx  = dfill_blk[IDXW-1:0];
        d_w_tag  = dfill_blk[BLKW-1:IDXW];
        d_w_data = dfill_state;
        if (co_done_ok) begin
            d_w_idx  = co_blk[IDXW-1:0];
            d_w_tag  = co_blk[BLKW-1:IDXW];
            d_w_data = co_next_q;
        end else if (dw_snp) begin
            d_w_idx  = snp_blk[IDXW-1:0];
            d_w_tag  = snp_blk[BLKW-1:IDXW];
            d_w_data = dw_state;
        end else begin
            d_we = dfill_valid;
        end
    end

    // Instruction-table write arbitration: snoop invalidate over fill.
    always_comb begin
        i_we     = i_clr || ifill_valid;
        i_w_idx  = i_clr ? snp_blk[IDXW-1:0] : ifill_blk[IDXW-1:0];
        i_w_tag  = i_clr ? snp_blk[BLKW-1:IDXW] : ifill_blk[BLKW-1:IDXW];
        i_w_data = i_clr ? 1'b0 : 1'b1;
    end

    // Registered bus responses and reserved-load outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_shared <= 1'b0;
            resp_retry  <= 1'b0;
            lr_hit      <= 1'b0;
            lr_atomic   <= 1'b0;
        end else begin
            resp_shared <= sh_d;
            resp_retry  <= rt_d;
            lr_hit      <= lr_req && d_hit[PLR];
            lr_atomic   <= lr_req && !d_hit[PLR];
        end
    end

    assign co_req      = co_busy;
    assign co_addr     = {co_blk, {OFFW{1'b0}}};
    assign look_dstate = d_data[PLK];
    assign look_ivalid = i_hit[PLK];

    // R12: no response without a preceding snoop.
    a_r12_quiet_without_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_valid |=> !resp_shared && !resp_retry);

    // R2: non-coherent snoops are never answered.
    a_r2_noncoherent_silent: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && !snp_wim[0] |=> !resp_shared && !resp_retry);

    // R6: pending castout forces retry alone.
    a_r6_retry_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && snp_wim[0] && co_req |=> resp_retry && !resp_shared);

    // R8: ordering snoop answers retry only.
    a_r8_order_retry: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && snp_wim[0] && !co_req && (snp_tt == TT_ORDER) |=> resp_retry && !resp_shared);

    // R7: instruction-invalidate snoop is silent on the bus.
    a_r7_icinv_silent: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid && snp_wim[0] && !co_req && (snp_tt == TT_ICINV) |=> !resp_retry && !resp_shared);

    // R11: a reserved load reports exactly one outcome.
    a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        lr_req |=> $countones({lr_hit, lr_atomic}) == 1);

    // R5: a castout begins only after a retried snoop answer.
    a_r5_castout_after_retry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(co_req) |-> resp_retry);
endmodule

// File: tb/tb_snoop_responder.sv
`timescale 1ns/1ps
module tb_snoop_responder;
    localparam int SETS = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        snp_valid = 0;
    logic [4:0]  snp_tt = 0;
    logic [2:0]  snp_wim = 0;
    logic [31:0] snp_addr = 0;
    logic        resp_shared, resp_retry, co_req;
    logic [31:0] co_addr;
    logic        co_ack = 0, co_ok = 0;
    logic        dfill_valid = 0;
    logic [31:0] dfill_addr = 0;
    logic [1:0]  dfill_state = 0;
    logic        ifill_valid = 0;
    logic [31:0] ifill_addr = 0;
    logic        lr_req = 0;
    logic [31:0] lr_addr = 0;
    logic        lr_hit, lr_atomic, rsv_valid;
    logic [31:0] look_addr = 0;
    logic [1:0]  look_dstate;
    logic        look_ivalid;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    bit cmp_en = 0;

    always #2 clk = ~clk;

    snoop_responder dut (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_tt(snp_tt), .snp_wim(snp_wim), .snp_addr(snp_addr),
        .resp_shared(resp_shared), .resp_retry(resp_retry),
        .co_req(co_req), .co_addr(co_addr), .co_ack(co_ack), .co_ok(co_ok),
        .dfill_valid(dfill_valid), .dfill_addr(dfill_addr), .dfill_state(dfill_state),
        .ifill_valid(ifill_valid), .ifill_addr(ifill_addr),
        .lr_req(lr_req), .lr_addr(lr_addr), .lr_hit(lr_hit), .lr_atomic(lr_atomic),
        .rsv_valid(rsv_valid),
        .look_addr(look_addr), .look_dstate(look_dstate), .look_ivalid(look_ivalid)
    );

    // ---------------- behavioural reference model ----------------
    int          m_tag [SETS];
    int          m_st  [SETS];
    int          i_tag [SETS];
    bit          i_v   [SETS];
    bit          m_busy;
    logic [31:0] m_coaddr;
    int          m_next;
    bit          m_rv;
    logic [26:0] m_rblk;
    bit          e_sh, e_rt, e_lh, e_la;
    string       lbl = "R12";

    function automatic int f_idx(logic [31:0] a); return int'(a[8:5]); endfunction
    function automatic int f_tag(logic [31:0] a); return int'(a[31:9]); endfunction

    always @(posedge clk) begin
        bit busy0, lrh;
        int ix, tg, st;
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                m_tag[s] = 0; m_st[s] = 0; i_tag[s] = 0; i_v[s] = 0;
            end
            m_busy = 0; m_coaddr = 0; m_next = 0; m_rv = 0; m_rblk = 0;
            e_sh = 0; e_rt = 0; e_lh = 0; e_la = 0; lbl = "R12";
        end else begin
            e_sh = 0; e_rt = 0; e_lh = 0; e_la = 0; lbl = "R12";
            busy0 = m_busy;
            lrh = (m_st[f_idx(lr_addr)] != 0) && (m_tag[f_idx(lr_addr)] == f_tag(lr_addr));
            if (co_ack && busy0) begin
                m_busy = 0;
                if (co_ok) m_st[f_idx(m_coaddr)] = m_next;
                lbl = (m_next == 2) ? "R5" : "R10";
            end
            if (snp_valid && !snp_wim[0]) lbl = "R2";
            if (snp_valid && snp_wim[0]) begin
                ix = f_idx(snp_addr); tg = f_tag(snp_addr);
                st = (m_tag[ix] == tg) ? m_st[ix] : 0;
                if (busy0) begin
                    e_rt = 1; lbl = "R6";
                end else begin
                    case (snp_tt)
                        5'b01011: begin
                            if (st == 3) begin
                                e_rt = 1; e_sh = 1; lbl = "R5";
                                m_busy = 1; m_coaddr = {snp_addr[31:5], 5'd0}; m_next = 2;
                            end else if (st != 0) begin
                                e_sh = 1; lbl = "R4";
                            end else lbl = "R3";
                        end
                        5'b01101: begin
                            lbl = "R7";
                            if (i_v[ix] && i_tag[ix] == tg) i_v[ix] = 0;
                        end
                        5'b10000: begin e_rt = 1; lbl = "R8"; end
                        5'b01100: begin
                            lbl = "R9";
                            if (st != 0) m_st[ix] = 0;
                            if (m_rv && m_rblk == snp_addr[31:5]) m_rv = 0;
                        end
                        5'b00100: begin
                            lbl = "R10";
                            if (st == 3) begin
                                e_rt = 1; m_busy = 1;
                                m_coaddr = {snp_addr[31:5], 5'd0}; m_next = 0;
                            end else if (st != 0) m_st[ix] = 0;
                        end
                        default: lbl = "R13";
                    endcase
                end
            end
            if (dfill_valid) begin
                m_tag[f_idx(dfill_addr)] = f_tag(dfill_addr);
                m_st[f_idx(dfill_addr)]  = int'(dfill_state);
            end
            if (ifill_valid) begin
                i_tag[f_idx(ifill_addr)] = f_tag(ifill_addr);
                i_v[f_idx(ifill_addr)]   = 1;
            end
            if (lr_req) begin
                e_lh = lrh; e_la = !lrh; m_rv = 1; m_rblk = lr_addr[31:5]; lbl = "R11";
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        int ix, tg, est;
        if (cmp_en && !finished) begin
            chk(lbl, {31'd0, resp_shared}, {31'd0, e_sh});
            chk(lbl, {31'd0, resp_retry},  {31'd0, e_rt});
            chk(lbl, {31'd0, co_req},      {31'd0, m_busy});
            if (m_busy) chk(lbl, co_addr, m_coaddr);
            chk(lbl, {31'd0, lr_hit},      {31'd0, e_lh});
            chk(lbl, {31'd0, lr_atomic},   {31'd0, e_la});
            chk(lbl, {31'd0, rsv_valid},   {31'd0, m_rv});
            ix = f_idx(look_addr); tg = f_tag(look_addr);
            est = (m_tag[ix] == tg) ? m_st[ix] : 0;
            chk("R1", {30'd0, look_dstate}, est[31:0]);
            chk("R1", {31'd0, look_ivalid}, {31'd0, (i_v[ix] && i_tag[ix] == tg)});
        end
    end

    // ---------------- stimulus ----------------
    task automatic tick(); @(posedge clk); #1; endtask
    task automatic quiet();
        snp_valid = 0; dfill_valid = 0; ifill_valid = 0; lr_req = 0; co_ack = 0;
    endtask
    task automatic snoop(logic [4:0] tt, logic [2:0] w, logic [31:0] a);
        quiet(); snp_valid = 1; snp_tt = tt; snp_wim = w; snp_addr = a; tick(); quiet();
    endtask
    task automatic dfill(logic [31:0] a, logic [1:0] s);
        quiet(); dfill_valid = 1; dfill_addr = a; dfill_state = s; tick(); quiet();
    endtask
    task automatic ifill(logic [31:0] a);
        quiet(); ifill_valid = 1; ifill_addr = a; tick(); quiet();
    endtask
    task automatic lrload(logic [31:0] a);
        quiet(); lr_req = 1; lr_addr = a; tick(); quiet();
    endtask
    task automatic ackc(logic ok);
        quiet(); co_ack = 1; co_ok = ok; tick(); quiet();
    endtask
    task automatic peek(logic [31:0] a); look_addr = a; #0.1; endtask

    function automatic logic [31:0] mk(int tg, int ix, int off);
        return {tg[22:0], ix[3:0], off[4:0]};
    endfunction

    initial begin
        logic [31:0] a, b;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cmp_en = 1;
        tick();
        // R12: reset state
        peek(mk(0, 0, 0));
        chk("R12", {31'd0, resp_shared}, 0);
        chk("R12", {31'd0, resp_retry}, 0);
        chk("R12", {31'd0, co_req}, 0);
        chk("R12", {31'd0, rsv_valid}, 0);
        chk("R12", {30'd0, look_dstate}, 0);

        a = mk(1, 1, 4); b = mk(2, 1, 4);
        dfill(a, 2'd2);
        peek(mk(1, 1, 31));
        chk("R1", {30'd0, look_dstate}, 2);
        snoop(5'b01011, 3'b001, mk(1, 1, 17));
        chk("R4", {30'd0, resp_retry, resp_shared}, 32'd1);
        snoop(5'b01011, 3'b110, a);
        chk("R2", {30'd0, resp_retry, resp_shared}, 32'd0);
        snoop(5'b01011, 3'b001, b);
        chk("R3", {30'd0, resp_retry, resp_shared}, 32'd0);

        dfill(a, 2'd3);
        snoop(5'b01011, 3'b001, a);
        chk("R5", {30'd0, resp_retry, resp_shared}, 32'd3);
        chk("R5", {31'd0, co_req}, 1);
        chk("R5", co_addr, mk(1, 1, 0));
        snoop(5'b10000, 3'b001, b);
        chk("R6", {30'd0, resp_retry, resp_shared}, 32'd2);
        ackc(1'b1);
        peek(a);
        chk("R5", {30'd0, look_dstate}, 2);
        dfill(a, 2'd3);
        snoop(5'b01011, 3'b001, a);
        ackc(1'b0);
        peek(a);
        chk("R5", {30'd0, look_dstate}, 3);

        ifill(mk(1, 2, 0));
        snoop(5'b01101, 3'b001, mk(2, 2, 0));
        peek(mk(1, 2, 9));
        chk("R7", {31'd0, look_ivalid}, 1);
        snoop(5'b01101, 3'b001, mk(1, 2, 3));
        chk("R7", {30'd0, resp_retry, resp_shared}, 32'd0);
        peek(mk(1, 2, 9));
        chk("R7", {31'd0, look_ivalid}, 0);

        snoop(5'b10000, 3'b001, a);
        chk("R8", {30'd0, resp_retry, resp_shared}, 32'd2);

        lrload(a);
        chk("R11", {30'd0, lr_atomic, lr_hit}, 32'd1);
        chk("R11", {31'd0, rsv_valid}, 1);
        snoop(5'b00100, 3'b001, a);
        chk("R10", {30'd0, resp_retry, resp_shared}, 32'd2);
        ackc(1'b1);
        peek(a);
        chk("R10", {30'd0, look_dstate}, 0);
        chk("R10", {31'd0, rsv_valid}, 1);
        lrload(a);
        chk("R11", {30'd0, lr_atomic, lr_hit}, 32'd2);
        dfill(mk(1, 3, 0), 2'd3);
        snoop(5'b01100, 3'b001, mk(1, 3, 7));
        chk("R9", {30'd0, resp_retry, resp_shared}, 32'd0);
        chk("R9", {31'd0, rsv_valid}, 1);
        snoop(5'b01100, 3'b001, a);
        chk("R9", {31'd0, rsv_valid}, 0);
        peek(mk(1, 3, 0));
        chk("R9", {30'd0, look_dstate}, 0);

        dfill(b, 2'd1);
        snoop(5'b00001, 3'b001, b);
        chk("R13", {30'd0, resp_retry, resp_shared}, 32'd0);
        peek(b);
        chk("R13", {30'd0, look_dstate}, 1);

        // Random phase: one action per cycle, data fills held while a castout is pending.
        for (int n = 0; n < 6000; n++) begin
            int act, pick;
            logic [4:0] tts [6];
            tts[0] = 5'b01011; tts[1] = 5'b01101; tts[2] = 5'b10000;
            tts[3] = 5'b01100; tts[4] = 5'b00100; tts[5] = 5'b00011;
            quiet();
            act = $urandom_range(0, 9);
            a = mk($urandom_range(1, 2), $urandom_range(0, 3), $urandom_range(0, 31));
            look_addr = mk($urandom_range(1, 2), $urandom_range(0, 3), $urandom_range(0, 31));
            co_ack = ($urandom_range(0, 3) == 0);
            co_ok  = $urandom_range(0, 1);
            if (act < 5) begin
                pick = (act < 2) ? 0 : $urandom_range(0, 5);
                snp_valid = 1; snp_tt = tts[pick]; snp_addr = a;
                snp_wim = 3'($urandom_range(0, 7)) | 3'(($urandom_range(0, 4) != 0) ? 1 : 0);
            end else if (act < 7) begin
                if (!m_busy) begin
                    dfill_valid = 1; dfill_addr = a; dfill_state = 2'($urandom_range(0, 3));
                end
            end else if (act == 7) begin
                ifill_valid = 1; ifill_addr = a;
            end else if (act == 8) begin
                lr_req = 1; lr_addr = a;
            end
            tick();
        end
        quiet();
        tick();
        tick();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL R12 watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule